// File: doc/BRIEF.md
# Serial Bus Hold Qualifier

This block supplies the pause function for the slave side of a serial flash style interface. It samples chip select, the serial clock, the serial data input and an active-low pause pin on the system clock. From these it produces a hold-active flag. While the flag is set, the serial output enable is forced off so the output pad floats, the serial clock and data seen by the shift logic are masked to zero, and the receive bit counter is frozen. When the pause is released, the transfer continues from the same bit position.

A pause starts on a falling edge of the pause pin and ends on a rising edge, but a change is only applied while the serial clock reads low. If the clock is high, the change waits until it goes low. Two configuration inputs, a pin-function select and a quad-enable bit, decide whether the pin acts as a pause pin at all. If chip select is released during a pause, the block issues a one-cycle interface reset request. It then refuses further transfers until it has seen the pause pin high while chip select is high. A busy flag from the program/erase sequencer passes straight through and is never affected by a pause.

Top module: `hold_qualifier`

## Requirements
- R1: While rst_n is low and in the first cycle after it, hold_active, rst_req, word_valid and bit_cnt are all 0.
- R2: With chip select low and the pause function enabled, a falling edge of hold_n sampled while sclk is low sets hold_active on the next clock.
- R3: If hold_n falls while sclk is sampled high, hold_active stays 0 until the first sample with sclk low, and is set on the clock after that sample.
- R4: A rising edge of hold_n clears hold_active on the next clock if sclk is low. If sclk is high, hold_active stays 1 until the clock after sclk is first sampled low.
- R5: While hold_active is 1, so_oe is 0 (output floats), and sclk_m and si_m are 0 whatever sclk and si do. so_out follows so_in.
- R6: Rising sclk edges sampled while hold_active is 1 do not change bit_cnt or the partial word. After the pause the word completes with the bits sent before and after it.
- R7: While cs_n is high, hold_active is 0 on the next clock and hold_n changes have no effect. A hold_n that is already low when cs_n falls does not start a pause.
- R8: If cs_n is sampled high while hold_active is 1, rst_req is 1 for exactly one cycle on the next clock and bit_cnt returns to 0. Releasing cs_n without a pause leaves rst_req at 0.
- R9: After a reset request, sclk edges are ignored (bit_cnt stays 0) until cs_n and hold_n are both sampled high. A later selection then counts bits from 0.
- R10: The pause function is enabled only when pin_fn_sel is 0 (0 = pause pin, 1 = reset pin) and quad_en is 0. While it is disabled, hold_n never sets hold_active. Disabling it during a pause clears hold_active on the next clock.
- R11: busy_out always equals busy_in, whether or not a pause is active.
- R12: Each sampled rising sclk edge with the bus selected and no pause shifts si into the word, most significant bit first by default, and increments bit_cnt. On the WORD_W-th bit, word_valid pulses for one cycle on the next clock, word_data holds the word, and bit_cnt wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock level |
| si | input | 1 | Serial data input |
| hold_n | input | 1 | Active-low pause pin |
| pin_fn_sel | input | 1 | Pin function: 0 pause, 1 reset |
| quad_en | input | 1 | Quad enable; 1 turns the pin into a data lane |
| so_in | input | 1 | Serial output data from the shift-out logic |
| so_oe_in | input | 1 | Output enable from the shift-out logic |
| busy_in | input | 1 | Program/erase busy flag |
| hold_active | output | 1 | Pause in force |
| sclk_m | output | 1 | Serial clock masked during a pause |
| si_m | output | 1 | Serial data masked during a pause |
| so_out | output | 1 | Serial output data to the pad |
| so_oe | output | 1 | Pad output enable; 0 means high impedance |
| rst_req | output | 1 | One-cycle interface reset request |
| bit_cnt | output | CNT_W | Bits received in the current word |
| word_valid | output | 1 | One-cycle pulse when a word completes |
| word_data | output | WORD_W | Last completed word |
| busy_out | output | 1 | Busy flag passed through |

## Verification
On every cycle, the assertions check four things: chip select high forces the pause flag off, a release during a pause produces the reset request, the flag rises or falls only after a sample with the clock low, and a frozen pause keeps the bit counter still. They also check that a completed word always follows the last bit position. Only the bench scenarios can show the rest. These are the postponement of entry and exit across a high clock, and the resumption of a word split by a pause. They also cover the lockout after a reset request and the need to see the pin high before it clears, and a pin already low at selection not starting a pause. A cycle model compares every output on every clock.

// File: rtl/hold_qual_pkg.sv
package hold_qual_pkg;

  // Pin function encoding: the shared pin acts as pause or as reset.
  typedef enum logic {
    PIN_PAUSE = 1'b0,
    PIN_RESET = 1'b1
  } pin_fn_e;

  // The pause pin is honoured only in pause mode with quad lanes off.
  function automatic logic pause_allowed(input logic fn_sel, input logic qe);
    return (fn_sel == PIN_PAUSE) && !qe;
  endfunction

  // Requested pause state after this sample's pin edges.
  function automatic logic pause_target(input logic fell, input logic rose,
                                        input logic prior);
    if (fell) return 1'b1;
    if (rose) return 1'b0;
    return prior;
  endfunction

  // A pending change may be applied only while the clock reads low.
  function automatic logic pause_apply(input logic clk_lvl, input logic target,
                                       input logic current);
    return clk_lvl ? current : target;
  endfunction

endpackage

// File: rtl/hold_edge_det.sv
module hold_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic hold_n,
  output logic hold_fall,
  output logic hold_rise,
  output logic sclk_rise
);
  logic holdn_q;
  logic sclk_q;

  // Previous levels are kept so pending changes act on the first low sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdn_q <= 1'b1;
      sclk_q  <= 1'b0;
    end else begin
      holdn_q <= hold_n;
      sclk_q  <= sclk;
    end
  end

  assign hold_fall = holdn_q & ~hold_n;
  assign hold_rise = ~holdn_q & hold_n;
  assign sclk_rise = sclk & ~sclk_q;

endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl
  import hold_qual_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic hold_n,
  input  logic hold_fall,
  input  logic hold_rise,
  input  logic enabled,
  output logic hold_active,
  output logic rst_req,
  output logic lockout
);
  logic want_q;
  logic target_c;
  logic blocked_c;
  logic release_evt;

  assign blocked_c   = cs_n | ~enabled | lockout;
  assign target_c    = pause_target(hold_fall, hold_rise, want_q);
  assign release_evt = hold_active & cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q      <= 1'b0;
      hold_active <= 1'b0;
    end else if (blocked_c) begin
      want_q      <= 1'b0;
      hold_active <= 1'b0;
    end else begin
      want_q      <= target_c;
      hold_active <= pause_apply(sclk, target_c, hold_active);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      lockout <= 1'b0;
    end else begin
      rst_req <= release_evt;
      if (release_evt)
        lockout <= 1'b1;
      else if (cs_n && hold_n)
        lockout <= 1'b0;
    end
  end

  // R7
  cs_hi_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !hold_active);
  // R8
  release_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && cs_n) |=> (rst_req && !hold_active));
  // R3
  entry_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active) |-> $past(!sclk));
  // R4
  exit_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_active) |-> ($past(!sclk) || $past(cs_n) || $past(!enabled)));
  // R10
  disabled_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> !hold_active);

endmodule

// File: rtl/hold_shift.sv
module hold_shift #(
  parameter int WORD_W    = 8,
  parameter bit MSB_FIRST = 1'b1,
  localparam int CNT_W    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              selected,
  input  logic              frozen,
  input  logic              sclk_rise,
  input  logic              si,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sreg;
  logic [WORD_W-1:0] shifted;
  logic              take_bit;

  generate
    if (MSB_FIRST) begin : g_msb
      assign shifted = {sreg[WORD_W-2:0], si};
    end else begin : g_lsb
      assign shifted = {si, sreg[WORD_W-1:1]};
    end
  endgenerate

  assign take_bit = selected & ~frozen & sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg       <= '0;
      bit_cnt    <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= 1'b0;
      if (!selected) begin
        sreg    <= '0;
        bit_cnt <= '0;
      end else if (take_bit) begin
        sreg <= shifted;
        if (bit_cnt == LAST_BIT) begin
          bit_cnt    <= '0;
          word_valid <= 1'b1;
          word_data  <= shifted;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R6
  frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && selected) |=> $stable(bit_cnt));
  // R12
  word_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> ($past(bit_cnt) == LAST_BIT));

endmodule

// File: rtl/hold_qualifier.sv
module hold_qualifier
  import hold_qual_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter bit MSB_FIRST = 1'b1,
  localparam int CNT_W    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              si,
  input  logic              hold_n,
  input  logic              pin_fn_sel,
  input  logic              quad_en,
  input  logic              so_in,
  input  logic              so_oe_in,
  input  logic              busy_in,
  output logic              hold_active,
  output logic              sclk_m,
  output logic              si_m,
  output logic              so_out,
  output logic              so_oe,
  output logic              rst_req,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              busy_out
);
  // Named internal events.
  logic hold_fall_w;
  logic hold_rise_w;
  logic sclk_rise_w;
  logic enabled_w;
  logic lockout_w;
  logic selected_w;

  assign enabled_w  = pause_allowed(pin_fn_sel, quad_en);
  assign selected_w = ~cs_n & ~lockout_w;

  hold_edge_det i_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .hold_n    (hold_n),
    .hold_fall (hold_fall_w),
    .hold_rise (hold_rise_w),
    .sclk_rise (sclk_rise_w)
  );

  hold_ctrl i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .hold_n      (hold_n),
    .hold_fall   (hold_fall_w),
    .hold_rise   (hold_rise_w),
    .enabled     (enabled_w),
    .hold_active (hold_active),
    .rst_req     (rst_req),
    .lockout     (lockout_w)
  );

  hold_shift #(
    .WORD_W    (WORD_W),
    .MSB_FIRST (MSB_FIRST)
  ) i_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .selected   (selected_w),
    .frozen     (hold_active),
    .sclk_rise  (sclk_rise_w),
    .si         (si),
    .bit_cnt    (bit_cnt),
    .word_valid (word_valid),
    .word_data  (word_data)
  );

  // Pad and shift-path masking while paused.
  assign sclk_m   = sclk & ~hold_active;
  assign si_m     = si & ~hold_active;
  assign so_out   = so_in;
  assign so_oe    = so_oe_in & ~hold_active;
  assign busy_out = busy_in;

  // R9
  lockout_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lockout_w && !(cs_n && hold_n)) |=> (bit_cnt == '0));
  // R5
  paused_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !so_oe);

endmodule

// File: tb/test_hold_qualifier.sv
module test_hold_qualifier;
  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, si, hold_n, pin_fn_sel, quad_en, so_in, so_oe_in, busy_in;
  logic hold_active, sclk_m, si_m, so_out, so_oe, rst_req, word_valid, busy_out;
  logic [2:0] bit_cnt;
  logic [7:0] word_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hold_qualifier i_hold_qualifier (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si), .hold_n(hold_n),
    .pin_fn_sel(pin_fn_sel), .quad_en(quad_en), .so_in(so_in), .so_oe_in(so_oe_in),
    .busy_in(busy_in), .hold_active(hold_active), .sclk_m(sclk_m), .si_m(si_m),
    .so_out(so_out), .so_oe(so_oe), .rst_req(rst_req), .bit_cnt(bit_cnt),
    .word_valid(word_valid), .word_data(word_data), .busy_out(busy_out)
  );

  // Behavioural reference model.
  bit m_hq, m_sq, m_want, m_hold, m_rst, m_lock, m_valid;
  int m_cnt, m_acc, m_word;

  always @(posedge clk) begin
    bit fall, rise, en, srise, sel, was;
    if (!rst_n) begin
      m_hq = 1; m_sq = 0; m_want = 0; m_hold = 0; m_rst = 0; m_lock = 0;
      m_valid = 0; m_cnt = 0; m_acc = 0; m_word = 0;
    end else begin
      fall = m_hq && !hold_n;
      rise = !m_hq && hold_n;
      en = !pin_fn_sel && !quad_en;
      srise = sclk && !m_sq;
      sel = !cs_n && !m_lock;
      was = m_hold;
      m_valid = 0;
      if (!sel) begin
        m_cnt = 0; m_acc = 0;
      end else if (!was && srise) begin
        m_acc = (m_acc * 2 + int'(si)) % 256;
        m_cnt++;
        if (m_cnt == 8) begin m_word = m_acc; m_valid = 1; m_cnt = 0; m_acc = 0; end
      end
      if (cs_n || !en || m_lock) begin
        m_want = 0; m_hold = 0;
      end else begin
        if (fall) m_want = 1;
        else if (rise) m_want = 0;
        if (!sclk) m_hold = m_want;
      end
      m_rst = was && cs_n;
      if (was && cs_n) m_lock = 1;
      else if (cs_n && hold_n) m_lock = 0;
      m_hq = hold_n; m_sq = sclk;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    if (!done) begin
      chk(hold_active == m_hold, "R2 model hold_active", hold_active, m_hold);
      chk(rst_req == m_rst, "R8 model rst_req", rst_req, m_rst);
      chk(int'(bit_cnt) == m_cnt, "R6 model bit_cnt", bit_cnt, m_cnt);
      chk(word_valid == m_valid, "R12 model word_valid", word_valid, m_valid);
      chk(int'(word_data) == m_word, "R12 model word_data", word_data, m_word);
      chk(so_oe == (so_oe_in && !m_hold), "R5 model so_oe", so_oe, so_oe_in && !m_hold);
      chk(sclk_m == (sclk && !m_hold), "R5 model sclk_m", sclk_m, sclk && !m_hold);
      chk(si_m == (si && !m_hold), "R5 model si_m", si_m, si && !m_hold);
      chk(so_out == so_in, "R5 model so_out", so_out, so_in);
      chk(busy_out == busy_in, "R11 model busy_out", busy_out, busy_in);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic send_bit(input bit b);
    si = b; sclk = 1; tick();
    sclk = 0; tick();
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int k = 7; k >= 0; k--) begin
      si = v[k]; sclk = 1; tick();
      if (k == 0) begin
        chk(word_valid == 1, "R12 valid", word_valid, 1);
        chk(word_data == v, "R12 data", word_data, v);
      end
      sclk = 0; tick();
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cs_n = 1; sclk = 0; si = 0; hold_n = 1; pin_fn_sel = 0; quad_en = 0;
    so_in = 1; so_oe_in = 1; busy_in = 0;
    tick(3);
    // R1
    chk(hold_active == 0, "R1 hold", hold_active, 0);
    chk(rst_req == 0, "R1 rst_req", rst_req, 0);
    chk(bit_cnt == 0, "R1 bit_cnt", bit_cnt, 0);
    rst_n = 1; tick();
    chk(word_valid == 0, "R1 valid", word_valid, 0);

    // R12 plain transfer
    cs_n = 0; tick();
    send_byte(8'hA5);

    // R2, R5, R6, R4: pause mid-word
    send_bit(0); send_bit(0); send_bit(1);
    chk(bit_cnt == 3, "R6 pre-pause cnt", bit_cnt, 3);
    hold_n = 0; tick();
    chk(hold_active == 1, "R2 entry", hold_active, 1);
    chk(so_oe == 0, "R5 so_oe", so_oe, 0);
    si = 1; sclk = 1; tick();
    chk(sclk_m == 0 && si_m == 0, "R5 masked", {sclk_m, si_m}, 0);
    chk(bit_cnt == 3, "R6 frozen", bit_cnt, 3);
    sclk = 0; tick(); sclk = 1; tick();
    hold_n = 1; tick();
    chk(hold_active == 1, "R4 exit waits", hold_active, 1);
    tick();
    chk(hold_active == 1, "R4 exit still waits", hold_active, 1);
    sclk = 0; tick();
    chk(hold_active == 0, "R4 exit", hold_active, 0);
    chk(bit_cnt == 3, "R6 resumed position", bit_cnt, 3);
    for (int k = 4; k >= 0; k--) begin
      si = k >= 2; sclk = 1; tick();
      if (k == 0) chk(word_data == 8'h3C && word_valid, "R6 joined word", word_data, 8'h3C);
      sclk = 0; tick();
    end

    // R3 postponed entry
    send_bit(1); send_bit(0);
    sclk = 1; tick();
    hold_n = 0; tick();
    chk(hold_active == 0, "R3 entry waits", hold_active, 0);
    tick();
    chk(hold_active == 0, "R3 entry still waits", hold_active, 0);
    sclk = 0; tick();
    chk(hold_active == 1, "R3 entry", hold_active, 1);

    // R8 release during pause
    cs_n = 1; tick();
    chk(rst_req == 1, "R8 request", rst_req, 1);
    chk(bit_cnt == 0, "R8 count cleared", bit_cnt, 0);
    tick();
    chk(rst_req == 0, "R8 single pulse", rst_req, 0);

    // R9 lockout
    cs_n = 0; tick();
    send_bit(1); send_bit(1);
    chk(bit_cnt == 0, "R9 locked", bit_cnt, 0);
    hold_n = 1; tick(); send_bit(1);
    chk(bit_cnt == 0, "R9 locked pin high", bit_cnt, 0);
    cs_n = 1; tick(2);
    cs_n = 0; tick(); send_bit(1);
    chk(bit_cnt == 1, "R9 unlocked", bit_cnt, 1);
    cs_n = 1; tick();

    // R7 deselected pin activity
    hold_n = 0; tick();
    chk(hold_active == 0, "R7 deselected", hold_active, 0);
    hold_n = 1; tick(); hold_n = 0; tick();
    cs_n = 0; tick();
    chk(hold_active == 0, "R7 low at select", hold_active, 0);
    send_bit(1);
    chk(bit_cnt == 1, "R7 no pause", bit_cnt, 1);
    hold_n = 1; tick(); cs_n = 1; tick();

    // R10 configuration
    pin_fn_sel = 1; cs_n = 0; tick();
    hold_n = 0; tick();
    chk(hold_active == 0, "R10 reset-pin mode", hold_active, 0);
    hold_n = 1; tick();
    pin_fn_sel = 0; quad_en = 1; hold_n = 0; tick();
    chk(hold_active == 0, "R10 quad mode", hold_active, 0);
    hold_n = 1; quad_en = 0; tick();
    hold_n = 0; tick();
    chk(hold_active == 1, "R10 enabled", hold_active, 1);
    quad_en = 1; tick();
    chk(hold_active == 0, "R10 disabled mid-pause", hold_active, 0);
    quad_en = 0; hold_n = 1; tick(); cs_n = 1; tick();
    chk(rst_req == 0, "R8 plain release", rst_req, 0);

    // R11 busy pass-through during pause
    cs_n = 0; tick(); hold_n = 0; tick();
    busy_in = 1; tick();
    chk(busy_out == 1 && hold_active == 1, "R11 busy high", busy_out, 1);
    busy_in = 0; tick();
    chk(busy_out == 0, "R11 busy low", busy_out, 0);
    hold_n = 1; tick(); cs_n = 1; tick(2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule